// File: doc/BRIEF.md
# Integer Operation Decoder (64-bit base set)

This block is a purely combinational decoder. It takes a 32-bit instruction word and recognises the four major opcode classes that perform integer arithmetic, logic, compare and shift work. These are the register-register class, its 32-bit word variant, the register-immediate class and its word variant. For each word it produces the following outputs:

- an ALU operation code;
- a flag that selects the immediate instead of the second register as the B operand;
- a word-mode flag that tells the ALU to work on 32 bits and sign-extend the result;
- the three register indices;
- the sign-extended 12-bit immediate;
- a shift amount.

Words from any other class are reported as not handled, so another decoder can claim them. Inside a handled class, an encoding outside the legal set raises the illegal flag. This includes immediate shifts whose upper immediate bits are not the exact qualifier pattern. When the illegal flag is raised, the operation and the write enable are forced inactive, so that nothing downstream can write the register file.

Top module: `iop_decode`

## Requirements
- R1: `rd_o`, `rs1_o` and `rs2_o` always equal instruction bits [11:7], [19:15] and [24:20].
- R2: `imm_o` always equals instruction bits [31:20] sign-extended to 64 bits.
- R3: A word is handled only when bits [1:0] are 11 and bits [6:2] are 01100 (register), 01110 (register word), 00100 (immediate) or 00110 (immediate word). Any other word gives `handled_o`=0, `illegal_o`=0, `wr_en_o`=0 and `op_o`=0.
- R4: The operation codes are NOP=0, ADD=1, SUB=2, SLL=3, SLT=4, SLTU=5, XOR=6, SRL=7, SRA=8, OR=9, AND=10. In the register class, funct3 (bits [14:12]) is decoded with funct7 (bits [31:25]) equal to 0000000 as follows: 000 ADD, 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL, 110 OR, 111 AND. With funct7 equal to 0100000, funct3 000 is SUB and 101 is SRA. Every other pair is illegal.
- R5: In the register word class, only ADD, SUB, SLL, SRL and SRA are legal, and they use the same funct3/funct7 pairs as in R4. Everything else is illegal.
- R6: In the immediate class, funct3 is decoded as 000 ADD, 010 SLT, 011 SLTU, 100 XOR, 110 OR and 111 AND, whatever the upper bits hold. In the immediate word class, only funct3 000 (ADD) is legal among the non-shift codes.
- R7: For a 64-bit immediate shift, the qualifier is bits [31:26]. With funct3 001 it must be 000000 (SLL). With funct3 101 it must be 000000 (SRL) or 010000 (SRA). Any other value is illegal.
- R8: For a word immediate shift, the qualifier is all of bits [31:25]. It must be 0000000 for SLL or SRL, or 0100000 for SRA with funct3 101. Any other value is illegal.
- R9: `wr_en_o` is 1 exactly when the word is handled and legal. When `illegal_o` is 1, `op_o` is NOP and `wr_en_o` is 0.
- R10: `use_imm_o` is 1 for the two immediate classes and `word_o` is 1 for the two word classes, whether or not the encoding is legal. Both are 0 for unhandled words.
- R11: In the 64-bit classes `shamt_o` equals bits [25:20]. In the word classes it equals bits [24:20] with a zero in bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| handled_o | output | 1 | Word belongs to one of the four integer-op classes |
| illegal_o | output | 1 | Handled class, but the encoding is not legal |
| wr_en_o | output | 1 | Destination register write allowed |
| op_o | output | 4 | ALU operation code (R4 encoding) |
| use_imm_o | output | 1 | B operand is the immediate |
| word_o | output | 1 | 32-bit word operation |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | 64 | Sign-extended I-type immediate |
| shamt_o | output | 6 | Shift amount |

## Verification
The bench first sweeps every funct3 value in each of the four classes against a set of upper-bit patterns. The patterns are zero, the alternate qualifier, bit 25 alone, bit 26 alone and bit 31 alone. Together they separate the six-bit qualifier of the 64-bit shifts from the seven-bit qualifier of the word shifts, and legal alternates from near misses. Words with the wrong low bits, or with load, branch and system opcodes, show whether the class gate keeps `handled_o` and `illegal_o` low. Thousands of random words, half of them steered into the handled classes, then cover immediate signs and shift amounts. Each word is compared field by field with a behavioural model.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int ILEN = 32;

  typedef enum logic [3:0] {
    IOP_NOP  = 4'd0,
    IOP_ADD  = 4'd1,
    IOP_SUB  = 4'd2,
    IOP_SLL  = 4'd3,
    IOP_SLT  = 4'd4,
    IOP_SLTU = 4'd5,
    IOP_XOR  = 4'd6,
    IOP_SRL  = 4'd7,
    IOP_SRA  = 4'd8,
    IOP_OR   = 4'd9,
    IOP_AND  = 4'd10
  } iop_op_e;

  localparam logic [4:0] MAJ_REG  = 5'b01100;
  localparam logic [4:0] MAJ_REGW = 5'b01110;
  localparam logic [4:0] MAJ_IMM  = 5'b00100;
  localparam logic [4:0] MAJ_IMMW = 5'b00110;

  localparam logic [6:0] F7_STD = 7'b0000000;
  localparam logic [6:0] F7_ALT = 7'b0100000;

  // Maps funct3 plus the "alternate" qualifier onto an operation code.
  function automatic iop_op_e base_op(input logic [2:0] f3, input logic alt);
    iop_op_e r;
    case (f3)
      3'b000:  r = alt ? IOP_SUB : IOP_ADD;
      3'b001:  r = IOP_SLL;
      3'b010:  r = IOP_SLT;
      3'b011:  r = IOP_SLTU;
      3'b100:  r = IOP_XOR;
      3'b101:  r = alt ? IOP_SRA : IOP_SRL;
      3'b110:  r = IOP_OR;
      default: r = IOP_AND;
    endcase
    return r;
  endfunction

  // Shift-type funct3 codes.
  function automatic logic is_shift_f3(input logic [2:0] f3);
    return (f3 == 3'b001) || (f3 == 3'b101);
  endfunction

endpackage

// File: rtl/iop_fields.sv
module iop_fields
  import iop_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [ILEN-1:0] instr_i,
  input  logic            word_i,
  output logic [4:0]      major_o,
  output logic [2:0]      f3_o,
  output logic [6:0]      f7_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [XLEN-1:0] imm_o,
  output logic [SHW-1:0]  shamt_o
);

  localparam int IMMW = 12;

  assign major_o = instr_i[6:2];
  assign f3_o    = instr_i[14:12];
  assign f7_o    = instr_i[31:25];
  assign rd_o    = instr_i[11:7];
  assign rs1_o   = instr_i[19:15];
  assign rs2_o   = instr_i[24:20];
  assign imm_o   = {{(XLEN-IMMW){instr_i[31]}}, instr_i[31:20]};

  generate
    if (SHW > 5) begin : g_wide_shamt
      assign shamt_o = word_i ? {{(SHW-5){1'b0}}, instr_i[24:20]}
                              : instr_i[20 +: SHW];
    end else begin : g_narrow_shamt
      logic unused_word;
      assign unused_word = word_i;
      assign shamt_o = instr_i[20 +: SHW];
    end
  endgenerate

endmodule

// File: rtl/iop_rr_dec.sv
module iop_rr_dec
  import iop_pkg::*;
(
  input  logic [2:0] f3_i,
  input  logic [6:0] f7_i,
  input  logic       word_i,
  output logic [3:0] op_o,
  output logic       legal_o
);

  logic std_q, alt_q, alt_ok;

  assign std_q  = (f7_i == F7_STD);
  assign alt_q  = (f7_i == F7_ALT);
  assign alt_ok = (f3_i == 3'b000) || (f3_i == 3'b101);

  always_comb begin
    if (word_i) begin
      if ((f3_i == 3'b000) || is_shift_f3(f3_i))
        legal_o = std_q || (alt_q && alt_ok);
      else
        legal_o = 1'b0;
    end else begin
      legal_o = std_q || (alt_q && alt_ok);
    end
    op_o = legal_o ? base_op(f3_i, alt_q) : IOP_NOP;
  end

endmodule

// File: rtl/iop_ri_dec.sv
module iop_ri_dec
  import iop_pkg::*;
(
  input  logic [2:0] f3_i,
  input  logic [6:0] f7_i,
  input  logic       word_i,
  output logic [3:0] op_o,
  output logic       legal_o
);

  logic std_q, alt_q;

  // 64-bit shifts qualify with the upper six bits, word shifts with all seven.
  always_comb begin
    if (word_i) begin
      std_q = (f7_i == F7_STD);
      alt_q = (f7_i == F7_ALT);
    end else begin
      std_q = (f7_i[6:1] == F7_STD[6:1]);
      alt_q = (f7_i[6:1] == F7_ALT[6:1]);
    end
  end

  always_comb begin
    case (f3_i)
      3'b000:  legal_o = 1'b1;
      3'b001:  legal_o = std_q;
      3'b101:  legal_o = std_q || alt_q;
      default: legal_o = !word_i;
    endcase
    op_o = legal_o ? base_op(f3_i, (f3_i == 3'b101) && alt_q) : IOP_NOP;
  end

endmodule

// File: rtl/iop_decode.sv
module iop_decode
  import iop_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [31:0]     instr_i,
  output logic            handled_o,
  output logic            illegal_o,
  output logic            wr_en_o,
  output logic [3:0]      op_o,
  output logic            use_imm_o,
  output logic            word_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [XLEN-1:0] imm_o,
  output logic [SHW-1:0]  shamt_o
);

  logic [4:0] major;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       full_len;
  logic       cls_reg, cls_imm, cls_word;
  logic [3:0] rr_op, ri_op;
  logic       rr_legal, ri_legal, sel_legal;

  assign full_len = (instr_i[1:0] == 2'b11);
  assign cls_reg  = full_len && ((major == MAJ_REG) || (major == MAJ_REGW));
  assign cls_imm  = full_len && ((major == MAJ_IMM) || (major == MAJ_IMMW));
  assign cls_word = full_len && ((major == MAJ_REGW) || (major == MAJ_IMMW));

  iop_fields #(.XLEN(XLEN)) u_fields (
    .instr_i (instr_i),
    .word_i  (cls_word),
    .major_o (major),
    .f3_o    (f3),
    .f7_o    (f7),
    .rd_o    (rd_o),
    .rs1_o   (rs1_o),
    .rs2_o   (rs2_o),
    .imm_o   (imm_o),
    .shamt_o (shamt_o)
  );

  iop_rr_dec u_rr (
    .f3_i    (f3),
    .f7_i    (f7),
    .word_i  (cls_word),
    .op_o    (rr_op),
    .legal_o (rr_legal)
  );

  iop_ri_dec u_ri (
    .f3_i    (f3),
    .f7_i    (f7),
    .word_i  (cls_word),
    .op_o    (ri_op),
    .legal_o (ri_legal)
  );

  assign sel_legal = cls_reg ? rr_legal : ri_legal;
  assign handled_o = cls_reg || cls_imm;
  assign illegal_o = handled_o && !sel_legal;
  assign wr_en_o   = handled_o && sel_legal;
  assign use_imm_o = cls_imm;
  assign word_o    = cls_word;
  assign op_o      = !wr_en_o ? IOP_NOP : (cls_reg ? rr_op : ri_op);

endmodule

// File: rtl/iop_decode_chk.sv
module iop_decode_chk
  import iop_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SHW = $clog2(XLEN)
) (
  input logic [31:0]     instr_i,
  input logic            handled_o,
  input logic            illegal_o,
  input logic            wr_en_o,
  input logic [3:0]      op_o,
  input logic            use_imm_o,
  input logic            word_o,
  input logic [XLEN-1:0] imm_o,
  input logic            rr_legal,
  input logic            ri_legal
);

  always_comb begin
    if (illegal_o)
      assert_illegal_quiet_R9: assert (op_o == IOP_NOP && !wr_en_o);
    if (!handled_o)
      assert_unhandled_silent_R3: assert (!illegal_o && !wr_en_o && op_o == IOP_NOP && !use_imm_o && !word_o);
    assert_imm_sign_R2: assert (imm_o[XLEN-1:12] == {(XLEN-12){instr_i[31]}});
    if (word_o && wr_en_o)
      assert_word_subset_R5: assert (op_o inside {IOP_ADD, IOP_SUB, IOP_SLL, IOP_SRL, IOP_SRA});
    if (use_imm_o && wr_en_o)
      assert_no_imm_sub_R6: assert (op_o != IOP_SUB && ri_legal);
    if (use_imm_o && !word_o && wr_en_o && op_o == IOP_SRA)
      assert_srai_qual_R7: assert (instr_i[31:26] == 6'b010000);
    if (use_imm_o && word_o && wr_en_o && (op_o == IOP_SLL || op_o == IOP_SRL || op_o == IOP_SRA))
      assert_word_shamt_R8: assert (instr_i[25] == 1'b0);
    if (handled_o && !use_imm_o)
      assert_reg_legal_R4: assert (wr_en_o == rr_legal);
  end

endmodule

bind iop_decode iop_decode_chk #(.XLEN(XLEN)) u_chk (
  .instr_i   (instr_i),
  .handled_o (handled_o),
  .illegal_o (illegal_o),
  .wr_en_o   (wr_en_o),
  .op_o      (op_o),
  .use_imm_o (use_imm_o),
  .word_o    (word_o),
  .imm_o     (imm_o),
  .rr_legal  (rr_legal),
  .ri_legal  (ri_legal)
);

// File: tb/sim_iop_decode.sv
`timescale 1ns/1ps
module sim_iop_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0;
  logic        handled, illegal, wr_en, use_imm, word;
  logic [3:0]  op;
  logic [4:0]  rd, rs1, rs2;
  logic [63:0] imm;
  logic [5:0]  shamt;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] vecs[$];

  always #10 clk = ~clk;

  iop_decode u0 (
    .instr_i   (instr),
    .handled_o (handled),
    .illegal_o (illegal),
    .wr_en_o   (wr_en),
    .op_o      (op),
    .use_imm_o (use_imm),
    .word_o    (word),
    .rd_o      (rd),
    .rs1_o     (rs1),
    .rs2_o     (rs2),
    .imm_o     (imm),
    .shamt_o   (shamt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: returns expected op (0 = none) and legality.
  task automatic model(input logic [31:0] w, output bit hnd, output bit ill,
                       output int eop, output bit eimm, output bit ewrd,
                       output string tag);
    int opc, f3, f7, f6;
    opc = w[6:2]; f3 = w[14:12]; f7 = w[31:25]; f6 = w[31:26];
    hnd = (w[1:0] == 2'b11) && (opc == 12 || opc == 14 || opc == 4 || opc == 6);
    eop = 0; ill = 0; tag = "R3";
    eimm = hnd && (opc == 4 || opc == 6);
    ewrd = hnd && (opc == 14 || opc == 6);
    if (hnd) begin
      if (opc == 12) begin
        tag = "R4";
        if (f7 == 0) begin
          case (f3) 0: eop = 1; 1: eop = 3; 2: eop = 4; 3: eop = 5;
                    4: eop = 6; 5: eop = 7; 6: eop = 9; default: eop = 10; endcase
        end else if (f7 == 32 && f3 == 0) eop = 2;
        else if (f7 == 32 && f3 == 5) eop = 8;
      end else if (opc == 14) begin
        tag = "R5";
        if (f7 == 0 && f3 == 0) eop = 1;
        else if (f7 == 0 && f3 == 1) eop = 3;
        else if (f7 == 0 && f3 == 5) eop = 7;
        else if (f7 == 32 && f3 == 0) eop = 2;
        else if (f7 == 32 && f3 == 5) eop = 8;
      end else if (opc == 4) begin
        tag = "R6";
        case (f3)
          0: eop = 1; 2: eop = 4; 3: eop = 5; 4: eop = 6; 6: eop = 9; 7: eop = 10;
          1: begin tag = "R7"; if (f6 == 0) eop = 3; end
          default: begin tag = "R7"; if (f6 == 0) eop = 7; else if (f6 == 16) eop = 8; end
        endcase
      end else begin
        tag = "R6";
        if (f3 == 0) eop = 1;
        else if (f3 == 1) begin tag = "R8"; if (f7 == 0) eop = 3; end
        else if (f3 == 5) begin tag = "R8"; if (f7 == 0) eop = 7; else if (f7 == 32) eop = 8; end
      end
      ill = (eop == 0);
    end
  endtask

  task automatic compare(input logic [31:0] w);
    bit hnd, ill, eimm, ewrd;
    int eop;
    string tag;
    logic [63:0] eimmv;
    logic [5:0]  esh;
    model(w, hnd, ill, eop, eimm, ewrd, tag);
    eimmv = w[31] ? {52'hF_FFFF_FFFF_FFFF, w[31:20]} : {52'h0, w[31:20]};
    esh = ewrd ? {1'b0, w[24:20]} : w[25:20];
    chk(handled == hnd, "R3", "handled", 64'(handled), 64'(hnd));
    chk(illegal == ill, tag, "illegal", 64'(illegal), 64'(ill));
    chk(int'(op) == eop, tag, "op", 64'(op), 64'(eop));
    chk(wr_en == (hnd && !ill), "R9", "wr_en", 64'(wr_en), 64'(hnd && !ill));
    chk(use_imm == eimm && word == ewrd, "R10", "imm/word flags",
        64'({use_imm, word}), 64'({eimm, ewrd}));
    chk(rd == w[11:7] && rs1 == w[19:15] && rs2 == w[24:20], "R1", "reg fields",
        64'({rd, rs1, rs2}), 64'({w[11:7], w[19:15], w[24:20]}));
    chk(imm == eimmv, "R2", "imm", imm, eimmv);
    if (hnd) chk(shamt == esh, "R11", "shamt", 64'(shamt), 64'(esh));
  endtask

  function automatic logic [31:0] mk(input int opc, input int f3, input int f7);
    logic [31:0] w;
    w = $urandom;
    w[31:25] = 7'(f7);
    w[14:12] = 3'(f3);
    w[6:2]   = 5'(opc);
    w[1:0]   = 2'b11;
    return w;
  endfunction

  initial begin
    int opcs[4];
    int f7s[5];
    opcs = '{12, 14, 4, 6};
    f7s  = '{0, 32, 1, 2, 64};
    foreach (opcs[i])
      for (int f3 = 0; f3 < 8; f3++)
        foreach (f7s[k]) vecs.push_back(mk(opcs[i], f3, f7s[k]));
    vecs.push_back(32'h0000_0013);
    vecs.push_back(32'h0000_0033 & 32'hFFFF_FFFC);   // right opcode, low bits 00
    vecs.push_back(32'h0000_3003);                   // load class
    vecs.push_back(32'h0000_0063);                   // branch class
    vecs.push_back(32'h0000_0073);                   // system class
    vecs.push_back(32'hFFF0_0013);                   // addi with -1
    vecs.push_back(32'h43F0_D013);                   // srai shamt 63
    vecs.push_back(32'h4200_D01B);                   // sraiw with bit 25 set
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 2 == 0) begin
        w[1:0] = 2'b11;
        w[6:2] = 5'(opcs[$urandom_range(0, 3)]);
        if (i % 4 == 0) w[31:25] = 7'(f7s[$urandom_range(0, 1)]);
      end
      vecs.push_back(w);
    end

    repeat (3) @(negedge clk);
    // reset state: all-zero word is not handled
    chk(!handled && !illegal && !wr_en && op == 4'd0, "R3", "idle word",
        64'({handled, illegal, wr_en, op}), 64'h0);
    rst_n = 1'b1;
    foreach (vecs[i]) begin
      @(posedge clk);
      instr <= vecs[i];
      @(negedge clk);
      compare(vecs[i]);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: act=%0d exp=%0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule